// File: doc/BRIEF.md
# Ethernet MAC Interrupt Event Aggregator

This block collects single-cycle event pulses from the transmit, receive, DMA and management logic of an Ethernet MAC. It holds them in a sticky event register. Software clears an event bit by writing a 1 to it. The block combines the held events into three registered interrupt lines for a programmable interrupt controller: one for transmit, one for receive and one for errors and diagnostics.

The two frame-complete events pass through a coalescing qualifier. A frame-complete bit raises its line only when coalescing is off for that direction or when the external coalescing logic reports that its threshold has been met. A per-bit mask register gates each event before the interrupt OR trees. A masked event is still latched and can still be read back.

Two events are qualified inside the block:
- A received control frame counts only while receive flow control is on. Such a frame also schedules a one-cycle pause request, which is issued once the current transmit frame has finished.
- An over-length received frame counts only while huge-frame mode is on.

Top module: `irq_evt_agg`

## Requirements
- R1: After reset every event bit is 0, every mask bit is 1 (enabled), and irqTx, irqRx, irqErr and pauseReq are 0.
- R2: Event bit positions: 0 tx-buffer, 1 tx-frame, 2 rx-buffer, 3 rx-frame, 4 magic packet, 5 graceful tx stop done, 6 graceful rx stop done, 7 tx control, 8 rx control, 9 babbling rx, 10 babbling tx, 11 late collision, 12 retry limit, 13 rx FIFO error, 14 queue FIFO error, 15 data parity, 16 parity, 17 bus error, 18 tx error, 19 tx underrun, 20 rx busy. A 1 on evtPulse[i] (i not 8 or 9) sets bit i at the next clock edge, and the bit stays set until it is cleared.
- R3: A write with regSel=0 clears every event bit whose regWrData bit is 1. Data bits that are 0 leave their event bits unchanged.
- R4: If an event sets a bit in the same cycle as a write clears it, the bit stays set.
- R5: irqTx is 1 when unmasked bit 0 is set, or when unmasked bit 1 is set and either coalEnTx is 0 or txThreshMet is 1.
- R6: irqRx is 1 when unmasked bit 2 is set, or when unmasked bit 3 is set and either coalEnRx is 0 or rxThreshMet is 1.
- R7: irqErr is the OR of unmasked bits 4 to 20. It stays 1 until all of those bits are cleared or masked.
- R8: A write with regSel=1 loads the mask register from regWrData. A masked event still latches and reads back with regSel=0, but it does not drive any interrupt. Reading with regSel=1 returns the mask.
- R9: Bit 8 sets only when ctrlFrameRx is 1 while rxFlowEn is 1. evtPulse[8] has no effect.
- R10: Bit 9 sets only when longFrameRx is 1 while hugeFrameEn is 1. evtPulse[9] has no effect.
- R11: A qualified control frame makes a request pending. pauseReq goes high for exactly one cycle, after the clock edge that ends the first later cycle in which txFrameBusy is 0.
- R12: regRdData follows the registers combinationally. The interrupt outputs change at the same clock edge as the event and mask registers, using the enable and threshold inputs sampled in the cycle before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 21 | Single-cycle event pulses, one per event bit |
| ctrlFrameRx | input | 1 | Control frame received |
| rxFlowEn | input | 1 | Receive flow control enabled |
| longFrameRx | input | 1 | Received frame exceeded the maximum length |
| hugeFrameEn | input | 1 | Huge-frame mode enabled |
| txFrameBusy | input | 1 | A transmit frame is in progress |
| coalEnTx | input | 1 | Transmit coalescing enabled |
| txThreshMet | input | 1 | Transmit coalescing threshold met |
| coalEnRx | input | 1 | Receive coalescing enabled |
| rxThreshMet | input | 1 | Receive coalescing threshold met |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the event register, 1 selects the mask register |
| regWrData | input | 21 | Write data |
| regRdData | output | 21 | Read data for the selected register |
| irqTx | output | 1 | Transmit interrupt |
| irqRx | output | 1 | Receive interrupt |
| irqErr | output | 1 | Error/diagnostic interrupt |
| pauseReq | output | 1 | One-cycle pause request |

## Verification
Event pulses, clearing writes, mask writes and the threshold inputs all act through one register stage. Their results on the event register, the mask, the three interrupt lines and the read port are therefore due right after the next rising edge. pauseReq is due one edge after the request becomes pending, and only in a cycle where txFrameBusy is low. The driver applies stimulus just after a falling edge and queues the expected values for the following rising edge. The monitor samples one time unit after each rising edge and compares that cycle's queued item, so the bench never samples at an edge.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int EVT_W = 21;

  localparam int B_TXB    = 0;
  localparam int B_TXF    = 1;
  localparam int B_RXB    = 2;
  localparam int B_RXF    = 3;
  localparam int B_ERR_LO = 4;
  localparam int B_RXCTL  = 8;
  localparam int B_BABRX  = 9;
  localparam int B_ERR_HI = EVT_W - 1;

  localparam logic SEL_EVT  = 1'b0;
  localparam logic SEL_MASK = 1'b1;

  function automatic logic [EVT_W-1:0] errGroup();
    logic [EVT_W-1:0] g;
    g = '0;
    for (int i = B_ERR_LO; i <= B_ERR_HI; i++) g[i] = 1'b1;
    return g;
  endfunction

  typedef struct packed {
    logic [EVT_W-1:0] setVec;
    logic [EVT_W-1:0] clrVec;
    logic             maskWe;
    logic [EVT_W-1:0] maskData;
  } evt_strobe_t;
endpackage

// File: rtl/irq_evt_ctrl.sv
module irq_evt_ctrl
  import irq_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [EVT_W-1:0] evtPulse,
  input  logic             ctrlFrameRx,
  input  logic             rxFlowEn,
  input  logic             longFrameRx,
  input  logic             hugeFrameEn,
  input  logic             txFrameBusy,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [EVT_W-1:0] regWrData,
  output evt_strobe_t      strb,
  output logic             pauseReq
);
  logic ctrlQual;
  logic pendQ;
  logic pauseQ;

  assign ctrlQual = ctrlFrameRx & rxFlowEn;

  // Build the strobes that the datapath applies at the next edge.
  always_comb begin
    strb = '0;
    strb.setVec          = evtPulse;
    strb.setVec[B_RXCTL] = ctrlQual;
    strb.setVec[B_BABRX] = longFrameRx & hugeFrameEn;
    strb.clrVec          = (regWrEn && regSel == SEL_EVT) ? regWrData : '0;
    strb.maskWe          = regWrEn && (regSel == SEL_MASK);
    strb.maskData        = regWrData;
  end

  // A pause request waits here until the transmitter is idle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ  <= 1'b0;
      pauseQ <= 1'b0;
    end else begin
      pauseQ <= pendQ & ~txFrameBusy;
      pendQ  <= ctrlQual | (pendQ & txFrameBusy);
    end
  end

  assign pauseReq = pauseQ;
endmodule

// File: rtl/irq_evt_dp.sv
module irq_evt_dp
  import irq_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  evt_strobe_t      strb,
  input  logic             coalEnTx,
  input  logic             txThreshMet,
  input  logic             coalEnRx,
  input  logic             rxThreshMet,
  output logic [EVT_W-1:0] evtQ,
  output logic [EVT_W-1:0] maskQ,
  output logic             irqTx,
  output logic             irqRx,
  output logic             irqErr
);
  localparam logic [EVT_W-1:0] ERR_GRP = errGroup();

  logic [EVT_W-1:0] evtNext;
  logic [EVT_W-1:0] maskNext;
  logic [EVT_W-1:0] liveNext;
  logic             txNext, rxNext, errNext;

  // A set in the same cycle as a clear wins.
  assign evtNext  = (evtQ & ~strb.clrVec) | strb.setVec;
  assign maskNext = strb.maskWe ? strb.maskData : maskQ;
  assign liveNext = evtNext & maskNext;

  for (genvar i = 0; i < EVT_W; i++) begin : g_evt
    logic bitQ;
    always_ff @(posedge clk) begin
      if (!rstN) bitQ <= 1'b0;
      else       bitQ <= evtNext[i];
    end
    assign evtQ[i] = bitQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskQ <= '1;
    else       maskQ <= maskNext;
  end

  function automatic logic dirIrq(input logic bufBit, input logic frmBit,
                                  input logic coalEn, input logic thr);
    return bufBit | (frmBit & (~coalEn | thr));
  endfunction

  assign txNext  = dirIrq(liveNext[B_TXB], liveNext[B_TXF], coalEnTx, txThreshMet);
  assign rxNext  = dirIrq(liveNext[B_RXB], liveNext[B_RXF], coalEnRx, rxThreshMet);
  assign errNext = |(liveNext & ERR_GRP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqTx  <= 1'b0;
      irqRx  <= 1'b0;
      irqErr <= 1'b0;
    end else begin
      irqTx  <= txNext;
      irqRx  <= rxNext;
      irqErr <= errNext;
    end
  end
endmodule

// File: rtl/irq_evt_agg.sv
module irq_evt_agg
  import irq_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [EVT_W-1:0] evtPulse,
  input  logic             ctrlFrameRx,
  input  logic             rxFlowEn,
  input  logic             longFrameRx,
  input  logic             hugeFrameEn,
  input  logic             txFrameBusy,
  input  logic             coalEnTx,
  input  logic             txThreshMet,
  input  logic             coalEnRx,
  input  logic             rxThreshMet,
  input  logic             regWrEn,
  input  logic             regSel,
  input  logic [EVT_W-1:0] regWrData,
  output logic [EVT_W-1:0] regRdData,
  output logic             irqTx,
  output logic             irqRx,
  output logic             irqErr,
  output logic             pauseReq
);
  evt_strobe_t      strb;
  logic [EVT_W-1:0] evtQ;
  logic [EVT_W-1:0] maskQ;
  logic [EVT_W-1:0] setVecW;

  assign setVecW = strb.setVec;

  irq_evt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse),
    .ctrlFrameRx(ctrlFrameRx), .rxFlowEn(rxFlowEn),
    .longFrameRx(longFrameRx), .hugeFrameEn(hugeFrameEn),
    .txFrameBusy(txFrameBusy), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .strb(strb), .pauseReq(pauseReq)
  );

  irq_evt_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .coalEnTx(coalEnTx), .txThreshMet(txThreshMet),
    .coalEnRx(coalEnRx), .rxThreshMet(rxThreshMet),
    .evtQ(evtQ), .maskQ(maskQ),
    .irqTx(irqTx), .irqRx(irqRx), .irqErr(irqErr)
  );

  assign regRdData = (regSel == SEL_MASK) ? maskQ : evtQ;
endmodule

// File: rtl/irq_evt_agg_chk.sv
module irq_evt_agg_chk
  import irq_evt_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic             regSel,
  input logic [EVT_W-1:0] regWrData,
  input logic [EVT_W-1:0] setVec,
  input logic [EVT_W-1:0] evtQ,
  input logic [EVT_W-1:0] maskQ,
  input logic             irqTx,
  input logic             irqRx,
  input logic             irqErr,
  input logic             pauseReq
);
  localparam logic [EVT_W-1:0] ERR_GRP = errGroup();

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regSel == SEL_EVT) |=> (($past(evtQ) & ~evtQ) == '0)); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == SEL_EVT) |=> ((evtQ & $past(regWrData) & ~$past(setVec)) == '0)); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(setVec) & ~evtQ) == '0)); // R4

  AST_TX_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irqTx |-> ((evtQ[B_TXB] & maskQ[B_TXB]) | (evtQ[B_TXF] & maskQ[B_TXF]))); // R5

  AST_RX_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irqRx |-> ((evtQ[B_RXB] & maskQ[B_RXB]) | (evtQ[B_RXF] & maskQ[B_RXF]))); // R6

  AST_ERR_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    irqErr == (|(evtQ & maskQ & ERR_GRP))); // R7

  AST_PAUSE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    pauseReq |=> !pauseReq); // R11
endmodule

bind irq_evt_agg irq_evt_agg_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
  .regWrData(regWrData), .setVec(setVecW), .evtQ(evtQ), .maskQ(maskQ),
  .irqTx(irqTx), .irqRx(irqRx), .irqErr(irqErr), .pauseReq(pauseReq)
);

// File: tb/irq_evt_agg_test.sv
module irq_evt_agg_test;
  import irq_evt_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [EVT_W-1:0] evtPulse = '0;
  logic ctrlFrameRx = 0, rxFlowEn = 0, longFrameRx = 0, hugeFrameEn = 0;
  logic txFrameBusy = 0, coalEnTx = 0, txThreshMet = 0, coalEnRx = 0, rxThreshMet = 0;
  logic regWrEn = 0, regSel = 0;
  logic [EVT_W-1:0] regWrData = '0;
  logic [EVT_W-1:0] regRdData;
  logic irqTx, irqRx, irqErr, pauseReq;

  always #5 clk = ~clk;

  irq_evt_agg uut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .ctrlFrameRx(ctrlFrameRx),
    .rxFlowEn(rxFlowEn), .longFrameRx(longFrameRx), .hugeFrameEn(hugeFrameEn),
    .txFrameBusy(txFrameBusy), .coalEnTx(coalEnTx), .txThreshMet(txThreshMet),
    .coalEnRx(coalEnRx), .rxThreshMet(rxThreshMet), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .regRdData(regRdData),
    .irqTx(irqTx), .irqRx(irqRx), .irqErr(irqErr), .pauseReq(pauseReq)
  );

  typedef struct {
    logic [EVT_W-1:0] rd;
    logic tx, rx, err, pause;
    string tag;
  } exp_t;

  exp_t expQ[$];
  int checkCnt = 0;
  int failCnt = 0;

  logic [EVT_W-1:0] mEvt = '0;
  logic [EVT_W-1:0] mMask = '1;
  logic mPend = 1'b0;

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: model the next state from the requirements and queue it.
  task automatic tick(string tag);
    logic [EVT_W-1:0] set, clr, nEvt, nMask, live;
    exp_t e;
    set = evtPulse;
    set[8] = ctrlFrameRx & rxFlowEn;
    set[9] = longFrameRx & hugeFrameEn;
    clr = (regWrEn && !regSel) ? regWrData : '0;
    nEvt = (mEvt & ~clr) | set;
    nMask = (regWrEn && regSel) ? regWrData : mMask;
    live = nEvt & nMask;
    e.tx = live[0] | (live[1] & (!coalEnTx | txThreshMet));
    e.rx = live[2] | (live[3] & (!coalEnRx | rxThreshMet));
    e.err = |live[20:4];
    e.pause = mPend & !txFrameBusy;
    e.rd = regSel ? nMask : nEvt;
    e.tag = tag;
    mPend = (ctrlFrameRx & rxFlowEn) | (mPend & txFrameBusy);
    mEvt = nEvt;
    mMask = nMask;
    expQ.push_back(e);
    @(negedge clk);
    evtPulse = '0; ctrlFrameRx = 0; longFrameRx = 0; regWrEn = 0; regWrData = '0;
  endtask

  task automatic clearEvt(logic [EVT_W-1:0] v, string tag);
    regWrEn = 1; regSel = 0; regWrData = v;
    tick(tag);
  endtask

  // Monitor: compare one time unit after each rising edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        cmp(e.tag, "rd", 32'(regRdData), 32'(e.rd));
        cmp(e.tag, "irqTx", 32'(irqTx), 32'(e.tx));
        cmp(e.tag, "irqRx", 32'(irqRx), 32'(e.rx));
        cmp(e.tag, "irqErr", 32'(irqErr), 32'(e.err));
        cmp(e.tag, "pauseReq", 32'(pauseReq), 32'(e.pause));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL R12 watchdog: actual still running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state observed at the ports
    cmp("R1", "irqs+pause", 32'({irqTx, irqRx, irqErr, pauseReq}), 32'h0);
    cmp("R1", "event reg", 32'(regRdData), 32'h0);
    regSel = 1; #1;
    cmp("R1", "mask reg", 32'(regRdData), 32'h1F_FFFF);
    regSel = 0;
    rstN = 1;
    tick("R1 idle");

    // R2 R5: tx-buffer raises irqTx; R3 clearing drops it
    evtPulse[0] = 1; tick("R2 R5 txb set");
    tick("R2 sticky hold");
    clearEvt(21'h0, "R3 zero write no effect");
    clearEvt(21'h1, "R3 clear txb");

    // R5: tx-frame qualified by coalescing
    coalEnTx = 1; txThreshMet = 0;
    evtPulse[1] = 1; tick("R5 txf gated");
    txThreshMet = 1; tick("R5 R12 threshold met");
    coalEnTx = 0; txThreshMet = 0; tick("R5 coalescing off");
    clearEvt(21'h2, "R5 clear txf");

    // R4: set and clear in one cycle
    evtPulse[0] = 1; clearEvt(21'h1, "R4 set wins");
    clearEvt(21'h1, "R4 cleared later");

    // R6: receive direction
    evtPulse[2] = 1; tick("R6 rxb set");
    clearEvt(21'h4, "R6 clear rxb");
    coalEnRx = 1; evtPulse[3] = 1; tick("R6 rxf gated");
    rxThreshMet = 1; tick("R6 threshold met");
    coalEnRx = 0; rxThreshMet = 0;
    clearEvt(21'h8, "R6 clear rxf");

    // R7: each error bit alone, then all cleared together
    for (int i = 4; i <= 20; i++) begin
      if (i != 8 && i != 9) begin
        evtPulse[i] = 1; tick("R7 R2 error bit");
        clearEvt(21'(1) << i, "R7 error cleared");
      end
    end
    evtPulse = 21'h1F_FCF0; tick("R7 many errors");
    clearEvt(21'h0F_FCF0, "R7 one bit still set");
    clearEvt(21'h10_0000, "R7 all cleared");

    // R9: rx control bit qualification and R11 pause request
    evtPulse[8] = 1; tick("R9 pulse ignored");
    ctrlFrameRx = 1; rxFlowEn = 0; tick("R9 flow off ignored");
    rxFlowEn = 1; txFrameBusy = 1; ctrlFrameRx = 1; tick("R9 R11 ctrl frame");
    tick("R11 tx busy holds");
    txFrameBusy = 0; tick("R11 pause issued");
    tick("R11 single pulse");
    ctrlFrameRx = 1; tick("R11 idle request");
    tick("R11 pause issued idle");
    clearEvt(21'h100, "R9 clear");

    // R10: babbling rx qualification
    evtPulse[9] = 1; tick("R10 pulse ignored");
    longFrameRx = 1; hugeFrameEn = 0; tick("R10 huge off ignored");
    longFrameRx = 1; hugeFrameEn = 1; tick("R10 long frame");
    clearEvt(21'h200, "R10 clear");

    // R8: mask
    regWrEn = 1; regSel = 1; regWrData = 21'h1F_FFFE; tick("R8 mask txb");
    regSel = 0; evtPulse[0] = 1; tick("R8 masked latched");
    regWrEn = 1; regSel = 1; regWrData = 21'h1F_FFFF; tick("R8 R12 unmask");
    regSel = 0; clearEvt(21'h1, "R8 clear");
    regWrEn = 1; regSel = 1; regWrData = 21'h00_000F; tick("R8 mask errors");
    regSel = 0; evtPulse[12] = 1; tick("R8 error masked");
    regSel = 1; tick("R8 mask readback");
    regSel = 0; clearEvt(21'h1000, "R8 clear error");

    wait (expQ.size() == 0);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end
endmodule